// File: doc/BRIEF.md
# Configurable Delay Timer with On-Delay, Retentive and Off-Delay Modes

This block is a single hardware timer that behaves like the three delay timer instructions found in ladder-logic controllers. A rung condition drives it. Depending on the selected personality, it measures how long the rung has been true (on-delay), how long the rung has been true in total across interruptions (retentive on-delay), or how long the rung has been false since it last dropped (off-delay). Elapsed time is counted in units of a selectable time base of 1 ms, 10 ms or 100 ms. The block derives each unit from the system clock through an internal prescaler.

The accumulated count and a done bit are the outputs. The done bit compares the count against a preset given in time-base units. The count never runs past the preset. In off-delay mode the done bit has the opposite sense: it is on while the rung is true and for the delay that follows, then goes off. The prescaler is restarted each time timing starts. The first count therefore always arrives one full time-base period after the start.

Top module: `ladder_delay_timer`

## Requirements
- R1: After reset the accumulated count is 0 and the done bit is 0, whatever the mode.
- R2: In on-delay mode (mode code 0), while the rung is true the count rises by one per time-base period, and done is 1 exactly when the rung is true and the count has reached the preset. A preset of 0 gives done as soon as the rung is true.
- R3: In on-delay mode a false rung drives done to 0 at once and returns the count to 0 at the next clock edge.
- R4: In retentive mode (mode code 1) the count rises only while the rung is true. It is kept unchanged while the rung is false, and the done bit stays as it was. Counting resumes from the kept value when the rung is true again.
- R5: In retentive mode the clear input overrides the rung: done is 0 while clear is high, and the count is 0 from the next clock edge for as long as clear stays high.
- R6: In off-delay mode (mode code 2) done is 1 whenever the rung is true, and the count is held at 0. After reset, with the rung false, done is 0.
- R7: In off-delay mode, after the rung falls the count rises by one per time-base period. Done stays 1 until the count reaches the preset and is 0 from then on.
- R8: In off-delay mode a rung that becomes true while the delay is running returns the count to 0 and keeps done at 1. A later fall starts a fresh full delay.
- R9: The count saturates at the preset and never rises beyond it.
- R10: Time-base code 0 selects 1 ms, code 1 selects 10 ms, and codes 2 and 3 select 100 ms, with one millisecond equal to CLK_HZ/1000 clock cycles. Timing starts on the rung rising edge (on-delay and retentive) or its falling edge (off-delay). The n-th count appears n·P+1 clock edges after the first edge that sees the new rung level, where P is the period in clocks.
- R11: Mode code 3 behaves exactly as on-delay mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rung | input | 1 | Rung condition that drives the timer |
| hold_clr | input | 1 | Clears the retentive count; ignored in other modes |
| preset | input | ACC_W | Delay length in time-base units |
| mode | input | 2 | 0 on-delay, 1 retentive, 2 off-delay, 3 on-delay |
| base_sel | input | 2 | 0 for 1 ms, 1 for 10 ms, 2 or 3 for 100 ms |
| acc | output | ACC_W | Accumulated time in time-base units |
| done | output | 1 | Timer done bit |

## Verification
The on-delay personality is swept over every time-base code and over presets of 0, 1 and 3, with a check after every clock edge. This confirms the period length for each base, the one-period latency after a start and saturation, and it tells a wrong period apart from a misplaced first tick. The retentive run alternates true, false and true rung spans, then asserts clear while the rung is true. This separates retained time from restarted time and shows that clear overrides the rung. The off-delay run covers the idle state after reset, a complete delay, and a retrigger in mid-delay followed by a fresh full delay. A short run with mode code 3 confirms that it maps onto on-delay.

// File: rtl/dly_tmr_pkg.sv
package dly_tmr_pkg;

  typedef enum logic [1:0] {
    TM_ON_DELAY  = 2'd0,
    TM_RETAIN    = 2'd1,
    TM_OFF_DELAY = 2'd2,
    TM_ON_ALT    = 2'd3
  } tmr_mode_e;

  // Clock cycles in one time-base unit for a given select code.
  function automatic int unsigned base_period(input logic [1:0] sel,
                                              input int unsigned tpm);
    case (sel)
      2'd0:    base_period = tpm;
      2'd1:    base_period = tpm * 10;
      default: base_period = tpm * 100;
    endcase
  endfunction

  // Whether the count has met the preset.
  function automatic logic limit_met(input logic [15:0] cnt,
                                     input logic [15:0] lim);
    limit_met = (cnt >= lim);
  endfunction

endpackage

// File: rtl/dly_tick_gen.sv
module dly_tick_gen #(
  parameter int unsigned TICKS_PER_MS = 100000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] base_sel,
  input  logic       restart,
  output logic       tick
);
  import dly_tmr_pkg::*;

  localparam int unsigned MAX_PERIOD = TICKS_PER_MS * 100;
  localparam int unsigned PW = (MAX_PERIOD > 2) ? $clog2(MAX_PERIOD) : 1;

  logic [PW-1:0] cnt_q;
  logic [PW-1:0] limit;
  logic          wrap;

  assign limit = PW'(base_period(base_sel, TICKS_PER_MS) - 1);
  assign wrap  = (cnt_q >= limit);
  assign tick  = wrap & ~restart;

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt_q <= '0;
    else if (restart || wrap)  cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

  // R10: a restart costs a full period, so no tick directly follows it
  a_r10_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && (TICKS_PER_MS > 1)) |=> !tick);

  // R10: ticks are single-cycle pulses when a period exceeds one clock
  a_r10_tick_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (TICKS_PER_MS > 1)) |=> !tick);

endmodule

// File: rtl/dly_accum.sv
module dly_accum #(
  parameter int unsigned ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  input  logic [ACC_W-1:0] preset,
  output logic [ACC_W-1:0] acc
);
  logic [ACC_W-1:0] acc_q;
  logic             below;

  assign below = (acc_q < preset);
  assign acc   = acc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             acc_q <= '0;
    else if (clr)           acc_q <= '0;
    else if (inc && below)  acc_q <= acc_q + 1'b1;
  end

  // R9: once at or past the preset the count does not move without a clear
  a_r9_hold_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !below) |=> (acc_q == $past(acc_q)));

  // R2: without a clear the count moves by at most one per cycle
  a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((acc_q == $past(acc_q)) || (acc_q == $past(acc_q) + 1'b1)));

  // R3, R5, R6: a clear always lands the count at zero
  a_r3_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc_q == '0));

endmodule

// File: rtl/dly_mode_ctrl.sv
module dly_mode_ctrl #(
  parameter int unsigned ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic             rung,
  input  logic             hold_clr,
  input  logic             tick,
  input  logic [ACC_W-1:0] acc,
  input  logic [ACC_W-1:0] preset,
  output logic             start,
  output logic             clr,
  output logic             inc,
  output logic             done
);
  import dly_tmr_pkg::*;

  tmr_mode_e m;
  logic      rung_q;
  logic      lat_q;
  logic      lat_d;
  logic      rise;
  logic      fall;
  logic      reached;
  logic      is_ton;
  logic      is_ret;
  logic      is_off;

  assign m       = tmr_mode_e'(mode);
  assign is_ton  = (m == TM_ON_DELAY) || (m == TM_ON_ALT);
  assign is_ret  = (m == TM_RETAIN);
  assign is_off  = (m == TM_OFF_DELAY);
  assign rise    = rung & ~rung_q;
  assign fall    = ~rung & rung_q;
  assign reached = limit_met(16'(acc), 16'(preset));

  always_comb begin
    start = 1'b0;
    clr   = 1'b0;
    inc   = 1'b0;
    done  = 1'b0;
    lat_d = 1'b0;
    if (is_ton) begin
      start = rise;
      clr   = ~rung;
      inc   = rung & tick;
      done  = rung & reached;
    end else if (is_ret) begin
      start = rise;
      clr   = hold_clr;
      inc   = rung & ~hold_clr & tick;
      done  = ~hold_clr & reached;
    end else if (is_off) begin
      start = fall;
      clr   = rung;
      inc   = ~rung & lat_q & tick;
      done  = rung | (lat_q & ~reached);
      lat_d = rung | (lat_q & ~reached);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rung_q <= 1'b0;
      lat_q  <= 1'b0;
    end else begin
      rung_q <= rung;
      lat_q  <= lat_d;
    end
  end

  // R6: off-delay output is on whenever the rung is true
  a_r6_off_rung_on: assert property (@(posedge clk) disable iff (!rst_n)
    (is_off && rung) |-> done);

  // R5: the retentive clear wins over the rung
  a_r5_clear_overrides: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ret && hold_clr) |-> !done);

  // R5: the count is zero one edge after the retentive clear
  a_r5_clear_acc: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ret && hold_clr) |=> (acc == '0));

  // R3: a false rung in on-delay mode keeps done off
  a_r3_ton_done_off: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ton && !rung) |-> !done);

  // R4: retentive count is frozen while the rung is false
  a_r4_retain_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ret && !rung && !hold_clr) |=> (acc == $past(acc)));

endmodule

// File: rtl/ladder_delay_timer.sv
module ladder_delay_timer #(
  parameter int unsigned CLK_HZ = 100000000,
  parameter int unsigned ACC_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rung,
  input  logic             hold_clr,
  input  logic [ACC_W-1:0] preset,
  input  logic [1:0]       mode,
  input  logic [1:0]       base_sel,
  output logic [ACC_W-1:0] acc,
  output logic             done
);
  localparam int unsigned TICKS_PER_MS = (CLK_HZ / 1000 > 0) ? CLK_HZ / 1000 : 1;

  logic tick;
  logic start;
  logic clr;
  logic inc;

  dly_tick_gen #(.TICKS_PER_MS(TICKS_PER_MS)) u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .base_sel (base_sel),
    .restart  (start),
    .tick     (tick)
  );

  dly_mode_ctrl #(.ACC_W(ACC_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .rung     (rung),
    .hold_clr (hold_clr),
    .tick     (tick),
    .acc      (acc),
    .preset   (preset),
    .start    (start),
    .clr      (clr),
    .inc      (inc),
    .done     (done)
  );

  dly_accum #(.ACC_W(ACC_W)) u_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr),
    .inc    (inc),
    .preset (preset),
    .acc    (acc)
  );

  // R1: reset leaves the outputs idle
  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |=> (acc == '0));

endmodule

// File: tb/test_ladder_delay_timer.sv
module test_ladder_delay_timer;
  localparam int CLK_HZ = 2000;
  localparam int TPM    = CLK_HZ / 1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rung = 1'b0;
  logic        hold_clr = 1'b0;
  logic [15:0] preset = '0;
  logic [1:0]  mode = 2'd0;
  logic [1:0]  base_sel = 2'd0;
  logic [15:0] acc;
  logic        done;

  int n_run = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  ladder_delay_timer #(.CLK_HZ(CLK_HZ), .ACC_W(16)) i_ladder_delay_timer (
    .clk(clk), .rst_n(rst_n), .rung(rung), .hold_clr(hold_clr),
    .preset(preset), .mode(mode), .base_sel(base_sel),
    .acc(acc), .done(done)
  );

  function automatic int period_of(input int sel);
    if (sel == 0) return TPM;
    if (sel == 1) return TPM * 10;
    return TPM * 100;
  endfunction

  function automatic int grown(input int k, input int per, input int lim);
    int v;
    v = (k < 1) ? 0 : (k - 1) / per;
    return (v > lim) ? lim : v;
  endfunction

  task automatic check(input string tag, input int got_acc, input int exp_acc,
                       input int got_done, input int exp_done);
    n_run++;
    if (got_acc != exp_acc || got_done != exp_done) begin
      n_bad++;
      $display("FAIL %s: acc=%0d done=%0d expected acc=%0d done=%0d",
               tag, got_acc, got_done, exp_acc, exp_done);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic at_neg;
    @(negedge clk);
  endtask

  task automatic do_reset;
    at_neg();
    rst_n = 1'b0;
    rung = 1'b0;
    hold_clr = 1'b0;
    edges(2);
    at_neg();
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    edges(1);
    check("R1 reset on-delay", acc, 0, done, 0);

    // R2, R3, R9, R10: on-delay sweep over every base code and several presets
    for (int b = 0; b < 4; b++) begin
      for (int pi = 0; pi < 3; pi++) begin
        int pv;
        int per;
        pv  = (pi == 0) ? 0 : ((pi == 1) ? 1 : 3);
        per = period_of(b);
        do_reset();
        mode = 2'd0; base_sel = 2'(b); preset = 16'(pv);
        edges(2);
        check("R1 idle before start", acc, 0, done, 0);
        at_neg();
        rung = 1'b1;
        for (int k = 1; k <= (pv + 1) * per + 2; k++) begin
          int e;
          edges(1);
          e = grown(k, per, pv);
          check($sformatf("R2 R10 R9 base%0d pre%0d k%0d", b, pv, k),
                acc, e, done, (e >= pv) ? 1 : 0);
        end
        at_neg();
        rung = 1'b0;
        #1;
        check("R3 done drops with rung", 32'(acc) >= 0 ? 0 : 1, 0, done, 0);
        edges(1);
        check("R3 count cleared", acc, 0, done, 0);
      end
    end

    // R4, R5, R9: retentive on 1 ms base (2 clocks), preset 6
    do_reset();
    mode = 2'd1; base_sel = 2'd0; preset = 16'd6;
    edges(1);
    check("R1 reset retentive", acc, 0, done, 0);
    at_neg(); rung = 1'b1;
    edges(5);
    check("R4 first span", acc, 2, done, 0);
    at_neg(); rung = 1'b0;
    edges(10);
    check("R4 kept while false", acc, 2, done, 0);
    at_neg(); rung = 1'b1;
    edges(7);
    check("R4 resumed", acc, 5, done, 0);
    at_neg(); hold_clr = 1'b1;
    #1;
    check("R5 done off under clear", 0, 0, done, 0);
    edges(1);
    check("R5 cleared with rung true", acc, 0, done, 0);
    edges(4);
    check("R5 clear holds count", acc, 0, done, 0);
    at_neg(); hold_clr = 1'b0; rung = 1'b0;
    edges(2);
    at_neg(); rung = 1'b1;
    edges(20);
    check("R4 reaches preset", acc, 6, done, 1);
    edges(10);
    check("R9 saturated retentive", acc, 6, done, 1);
    at_neg(); rung = 1'b0;
    edges(5);
    check("R4 done retained", acc, 6, done, 1);

    // R6, R7, R8: off-delay on 10 ms base (20 clocks), preset 2
    do_reset();
    mode = 2'd2; base_sel = 2'd1; preset = 16'd2;
    edges(3);
    check("R6 idle after reset", acc, 0, done, 0);
    at_neg(); rung = 1'b1;
    #1;
    check("R6 on with rung", 0, 0, done, 1);
    edges(3);
    check("R6 count held zero", acc, 0, done, 1);
    at_neg(); rung = 1'b0;
    for (int k = 1; k <= 45; k++) begin
      int e;
      edges(1);
      e = grown(k, 20, 2);
      check($sformatf("R7 off-delay k%0d", k), acc, e, done, (e < 2) ? 1 : 0);
    end
    at_neg(); rung = 1'b1;
    edges(2);
    at_neg(); rung = 1'b0;
    edges(25);
    check("R8 mid delay", acc, 1, done, 1);
    at_neg(); rung = 1'b1;
    edges(1);
    check("R8 retrigger clears", acc, 0, done, 1);
    edges(3);
    check("R8 stays on", acc, 0, done, 1);
    at_neg(); rung = 1'b0;
    edges(40);
    check("R8 fresh delay near end", acc, 1, done, 1);
    edges(1);
    check("R8 fresh delay expired", acc, 2, done, 0);
    edges(30);
    check("R9 off-delay saturated", acc, 2, done, 0);

    // R11: mode code 3 acts as on-delay
    do_reset();
    mode = 2'd3; base_sel = 2'd0; preset = 16'd1;
    edges(1);
    at_neg(); rung = 1'b1;
    edges(2);
    check("R11 before first count", acc, 0, done, 0);
    edges(1);
    check("R11 counted", acc, 1, done, 1);
    at_neg(); rung = 1'b0;
    edges(1);
    check("R11 cleared on false", acc, 0, done, 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule